// File: doc/BRIEF.md
# Capture/Reload Timer-Counter

This block is a 16-bit up-counter with an 8-bit control/status byte. It counts either internal clock-enable ticks or falling edges on an external count pin. On overflow it can load itself again from a 16-bit reload/capture register. A falling edge on a separate trigger pin can either load the counter from that register or copy the running count into it. An overflow flag and an external-event flag are combined into one interrupt request. Software clears both flags; the hardware never clears them.

Either of two baud-select bits puts the block into baud mode. In this mode it always reloads on overflow and sends a one-cycle tick toward the transmit and/or receive clock of a serial port. While baud mode is on, the overflow flag is not set.

Software uses one byte-wide register port to reach the control byte, the count and the reload value. It can also set or clear any single control bit through a separate bit-write port.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the control byte, count and reload value all read 0. The `irq`, `baud_tx_tick` and `baud_rx_tick` outputs are 0.
- R2: Control bit 2 (run) gates counting. While it is 0 the count holds, except for register writes and trigger reloads.
- R3: Control bit 1 (source) selects what is counted. With 0, each cycle with `tick_en`=1 adds one. With 1, each falling edge of `cnt_pin` adds one. The edge is seen through a two-flop synchronizer and acts at the third rising clock edge after the pin falls.
- R4: With bit 0 (mode) = 0 and no baud select, an overflow from FFFFh loads the reload value into the count. With mode = 1 the count wraps to 0.
- R5: With bit 3 (trigger enable) = 1, mode = 0 and no baud select, a synchronized falling edge of `trig_pin` loads the reload value into the count. This takes priority over an increment in the same cycle.
- R6: With trigger enable = 1, mode = 1 and no baud select, a falling trigger edge copies the count, as it was before that edge's update, into the reload register.
- R7: Bit 6 (external flag) is set by every falling trigger edge seen while trigger enable = 1. When trigger enable is 0 the trigger pin has no effect on count, reload value or flags.
- R8: Bit 7 (overflow flag) is set on overflow only while bits 5 and 4 are both 0. Bits 7 and 6 stay set until software writes 0 to them. A hardware set wins over a software clear in the same cycle.
- R9: Bit 4 (transmit baud) and bit 5 (receive baud) each choose baud mode for their direction. With either bit set, overflow always reloads the count, and the trigger never reloads or captures. Each overflow gives a one-cycle pulse on `baud_tx_tick` when bit 4 is set and on `baud_rx_tick` when bit 5 is set. The pulse appears one cycle after the overflow edge.
- R10: `irq` equals `irq_en` AND (bit 7 OR bit 6).
- R11: Address map for byte access: 0 is the control byte, 1 is the count low byte, 2 is the count high byte, 3 is the reload low byte and 4 is the reload high byte. `rdata` shows the addressed register combinationally. A byte write takes effect at the next edge and wins over counter activity. A bit write puts `bit_val` into control bit `bit_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Internal count tick |
| cnt_pin | input | 1 | External count pin, asynchronous |
| trig_pin | input | 1 | External capture/reload trigger, asynchronous |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Byte write data |
| rdata | output | 8 | Read data of addressed register |
| bit_wr | input | 1 | Single control-bit write strobe |
| bit_idx | input | 3 | Control bit to write |
| bit_val | input | 1 | Value for the control bit |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| baud_tx_tick | output | 1 | Transmit baud tick |
| baud_rx_tick | output | 1 | Receive baud tick |

## Verification
The assertions check three things on every cycle. The count holds while stopped with the trigger disabled. Both flags stay set until software clears them, and the overflow flag never rises in baud mode. A baud tick appears only when its direction bit was set. The bench's scenarios are needed for the rest. These are the reload and capture values, the three-edge latency of the synchronized pins, the priority of a trigger reload over an increment, and the tick spacing in baud mode. A behavioural model, compared every cycle through the read port, covers these, including during a pseudo-random stretch.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int CTRL_W   = 8;
  localparam int B_MODE   = 0;  // 1: capture on trigger, 0: reload
  localparam int B_SRC    = 1;  // 1: external pin edges
  localparam int B_RUN    = 2;
  localparam int B_TRGEN  = 3;
  localparam int B_TXBAUD = 4;
  localparam int B_RXBAUD = 5;
  localparam int B_EXTF   = 6;
  localparam int B_OVFF   = 7;
endpackage

// File: rtl/crt_fall_detect.sv
module crt_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // oldest stage is the previous synchronized sample
  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/crt_ctrl_reg.sv
module crt_ctrl_reg
  import crt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              bit_wr,
  input  logic [2:0]        bit_idx,
  input  logic              bit_val,
  input  logic              set_ovf,
  input  logic              set_ext,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (byte_wr) ctrl_d = wdata;
    if (bit_wr)  ctrl_d[bit_idx] = bit_val;
    if (set_ovf) ctrl_d[B_OVFF] = 1'b1;
    if (set_ext) ctrl_d[B_EXTF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/crt_count_core.sv
module crt_count_core #(
  parameter int CNT_W = 16,
  parameter int LANES = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_ext,
  input  logic             cap_mode,
  input  logic             baud,
  input  logic             tick_en,
  input  logic             cnt_fall,
  input  logic             trig_evt,
  input  logic [LANES-1:0] cnt_wr_lane,
  input  logic [LANES-1:0] rl_wr_lane,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rl_q,
  output logic             ovf
);
  logic             inc, reload_ovf, trig_reload, trig_capture;
  logic [CNT_W-1:0] cnt_d, rl_d;

  assign inc          = run & (src_ext ? cnt_fall : tick_en);
  assign ovf          = inc & (&cnt_q);
  assign reload_ovf   = ovf & (baud | ~cap_mode);
  assign trig_reload  = trig_evt & ~baud & ~cap_mode;
  assign trig_capture = trig_evt & ~baud & cap_mode;

  always_comb begin
    cnt_d = cnt_q;
    if (reload_ovf || trig_reload) cnt_d = rl_q;
    else if (inc)                  cnt_d = cnt_q + CNT_W'(1);
    rl_d = rl_q;
    if (trig_capture) rl_d = cnt_q;
    for (int i = 0; i < LANES; i++) begin
      if (cnt_wr_lane[i]) cnt_d[i*8 +: 8] = wdata;
      if (rl_wr_lane[i])  rl_d[i*8 +: 8]  = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rl_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      rl_q  <= rl_d;
    end
  end
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              bit_wr,
  input  logic [2:0]        bit_idx,
  input  logic              bit_val,
  input  logic              irq_en,
  output logic              irq,
  output logic              baud_tx_tick,
  output logic              baud_rx_tick
);
  localparam int LANES = CNT_W / 8;
  localparam int NPINS = 2;

  logic [NPINS-1:0]  pins, falls;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q, rl_q;
  logic [LANES-1:0]  cnt_wr_lane, rl_wr_lane;
  logic              ctrl_wr, baud, trig_evt, ovf;
  logic              tx_tick_q, rx_tick_q, tx_tick_d, rx_tick_d;

  assign pins = {trig_pin, cnt_pin};

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    crt_fall_detect #(.STAGES(2)) u_fall (
      .clk(clk), .rst_n(rst_n), .pin(pins[p]), .fall(falls[p])
    );
  end

  assign ctrl_wr = wr_en && (addr == '0);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cnt_wr_lane[l] = wr_en && (addr == ADDR_W'(1 + l));
    assign rl_wr_lane[l]  = wr_en && (addr == ADDR_W'(1 + LANES + l));
  end

  assign baud     = ctrl_q[B_TXBAUD] | ctrl_q[B_RXBAUD];
  assign trig_evt = falls[1] & ctrl_q[B_TRGEN];

  crt_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_wr(ctrl_wr), .wdata(wdata),
    .bit_wr(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val),
    .set_ovf(ovf & ~baud), .set_ext(trig_evt), .ctrl_q(ctrl_q)
  );

  crt_count_core #(.CNT_W(CNT_W), .LANES(LANES)) u_core (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[B_RUN]), .src_ext(ctrl_q[B_SRC]),
    .cap_mode(ctrl_q[B_MODE]), .baud(baud), .tick_en(tick_en),
    .cnt_fall(falls[0]), .trig_evt(trig_evt), .cnt_wr_lane(cnt_wr_lane),
    .rl_wr_lane(rl_wr_lane), .wdata(wdata), .cnt_q(cnt_q), .rl_q(rl_q),
    .ovf(ovf)
  );

  always_comb begin
    tx_tick_d = ovf & ctrl_q[B_TXBAUD];
    rx_tick_d = ovf & ctrl_q[B_RXBAUD];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_tick_q <= 1'b0;
      rx_tick_q <= 1'b0;
    end else begin
      tx_tick_q <= tx_tick_d;
      rx_tick_q <= rx_tick_d;
    end
  end

  assign baud_tx_tick = tx_tick_q;
  assign baud_rx_tick = rx_tick_q;
  assign irq = irq_en & (ctrl_q[B_OVFF] | ctrl_q[B_EXTF]);

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata = ctrl_q;
    for (int i = 0; i < LANES; i++) begin
      if (addr == ADDR_W'(1 + i))         rdata = cnt_q[i*8 +: 8];
      if (addr == ADDR_W'(1 + LANES + i)) rdata = rl_q[i*8 +: 8];
    end
  end
endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              bit_wr,
  input logic [2:0]        bit_idx,
  input logic [7:0]        ctrl_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              baud_tx_tick,
  input logic              baud_rx_tick
);
  logic byte_ctrl, clr7, clr6;
  assign byte_ctrl = wr_en && (addr == '0);
  assign clr7 = byte_ctrl || (bit_wr && bit_idx == 3'd7);
  assign clr6 = byte_ctrl || (bit_wr && bit_idx == 3'd6);

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[2] && !ctrl_q[3] && !wr_en) |=> $stable(cnt_q)); // R2
  AST_EXT_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] && !clr6) |=> ctrl_q[6]); // R7
  AST_OVF_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] && !clr7) |=> ctrl_q[7]); // R8
  AST_NO_OVF_FLAG_IN_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q[4] || ctrl_q[5]) && !ctrl_q[7] && !clr7) |=> !ctrl_q[7]); // R8
  AST_TX_TICK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tx_tick |-> $past(ctrl_q[4])); // R9
  AST_RX_TICK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    baud_rx_tick |-> $past(ctrl_q[5])); // R9
endmodule

bind cap_reload_timer crt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .bit_wr(bit_wr),
  .bit_idx(bit_idx), .ctrl_q(ctrl_q), .cnt_q(cnt_q),
  .baud_tx_tick(baud_tx_tick), .baud_rx_tick(baud_rx_tick)
);

// File: tb/cap_reload_timer_test.sv
module cap_reload_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1;
  logic       wr_en = 1'b0, bit_wr = 1'b0, bit_val = 1'b0, irq_en = 1'b0;
  logic [2:0] addr = '0, bit_idx = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, baud_tx_tick, baud_rx_tick;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  int m_ctrl, m_cnt, m_rl, m_tx, m_rx;
  int cq[$], tq[$];

  always #5 clk = ~clk;

  cap_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .bit_wr(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val),
    .irq_en(irq_en), .irq(irq), .baud_tx_tick(baud_tx_tick),
    .baud_rx_tick(baud_rx_tick)
  );

  function automatic int bitof(int v, int b);
    return (v >> b) & 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_rl = 0; m_tx = 0; m_rx = 0;
      cq = '{0, 0, 0}; tq = '{0, 0, 0};
    end else begin
      int cf, tf, inc, ov, bd, te, nc, nr, nt;
      // queue front = newest sample; [1] synchronized, [2] previous
      cf  = cq[2] & ~cq[1];
      tf  = tq[2] & ~tq[1];
      inc = bitof(m_ctrl, 2) && (bitof(m_ctrl, 1) ? cf : tick_en);
      ov  = inc && (m_cnt == 65535);
      bd  = bitof(m_ctrl, 4) || bitof(m_ctrl, 5);
      te  = tf && bitof(m_ctrl, 3);
      nc = m_cnt; nr = m_rl; nt = m_ctrl;
      if (ov && (bd || !bitof(m_ctrl, 0)))    nc = m_rl;
      else if (te && !bd && !bitof(m_ctrl, 0)) nc = m_rl;
      else if (inc)                            nc = (m_cnt + 1) % 65536;
      if (te && !bd && bitof(m_ctrl, 0)) nr = m_cnt;
      if (wr_en) begin
        case (addr)
          3'd0: nt = wdata;
          3'd1: nc = (nc & 16'hFF00) | wdata;
          3'd2: nc = (nc & 16'h00FF) | (int'(wdata) << 8);
          3'd3: nr = (nr & 16'hFF00) | wdata;
          3'd4: nr = (nr & 16'h00FF) | (int'(wdata) << 8);
          default: ;
        endcase
      end
      if (bit_wr) nt = bit_val ? (nt | (1 << bit_idx)) : (nt & ~(1 << bit_idx));
      if (ov && !bd) nt = nt | 8'h80;
      if (te)        nt = nt | 8'h40;
      m_tx = ov && bitof(m_ctrl, 4);
      m_rx = ov && bitof(m_ctrl, 5);
      m_ctrl = nt; m_cnt = nc; m_rl = nr;
      cq.push_front(int'(cnt_pin)); void'(cq.pop_back());
      tq.push_front(int'(trig_pin)); void'(tq.pop_back());
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a; #1 v = rdata;
  endtask

  // advance one clock, then compare every output and register with the model
  task automatic step();
    int v, lo, hi;
    @(posedge clk); #1;
    wr_en = 1'b0; bit_wr = 1'b0;
    chk("R10 irq", irq, irq_en && ((m_ctrl & 8'hC0) != 0));
    chk("R9 tx tick", baud_tx_tick, m_tx);
    chk("R9 rx tick", baud_rx_tick, m_rx);
    rd(3'd0, v);  chk("R11 ctrl", v, m_ctrl);
    rd(3'd1, lo); rd(3'd2, hi); chk("R3 count", hi * 256 + lo, m_cnt);
    rd(3'd3, lo); rd(3'd4, hi); chk("R6 reload", hi * 256 + lo, m_rl);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d; step();
  endtask

  task automatic bwr(input logic [2:0] i, input logic v);
    bit_wr = 1'b1; bit_idx = i; bit_val = v; step();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic rd16(input logic [2:0] a, output int v);
    int lo, hi;
    rd(a, lo); rd(a + 3'd1, hi); v = hi * 256 + lo;
  endtask

  initial begin
    int v, nt;
    logic [15:0] lfsr;
    #12 rst_n = 1'b1;
    #1;
    rd(3'd0, v); chk("R1 ctrl reset", v, 0);
    rd16(3'd1, v); chk("R1 count reset", v, 0);
    rd16(3'd3, v); chk("R1 reload reset", v, 0);
    chk("R1 irq reset", irq, 0);

    // R4: overflow reload in timer mode
    wr(3'd3, 8'hF0); wr(3'd4, 8'hFF); wr(3'd1, 8'hFD); wr(3'd2, 8'hFF);
    wr(3'd0, 8'h04);
    irq_en = 1'b1; tick_en = 1'b1; steps(3); tick_en = 1'b0;
    rd16(3'd1, v); chk("R4 reload after overflow", v, 16'hFFF0);
    rd(3'd0, v);   chk("R8 overflow flag", v, 8'h84);
    chk("R10 irq raised", irq, 1);
    bwr(3'd7, 1'b0);
    chk("R10 irq cleared", irq, 0);
    // R2: stopped count holds
    bwr(3'd2, 1'b0);
    tick_en = 1'b1; steps(5);
    rd16(3'd1, v); chk("R2 hold while stopped", v, 16'hFFF0);
    // R3: external count edges, tick_en ignored
    wr(3'd0, 8'h06);
    for (int k = 0; k < 3; k++) begin
      cnt_pin = 1'b0; steps(2); cnt_pin = 1'b1; steps(2);
    end
    steps(4);
    rd16(3'd1, v); chk("R3 three pin edges", v, 16'hFFF3);
    // R7: trigger ignored when disabled
    trig_pin = 1'b0; steps(3); trig_pin = 1'b1; steps(4);
    rd16(3'd1, v); chk("R7 count untouched", v, 16'hFFF3);
    rd(3'd0, v);   chk("R7 no flag when disabled", v, 8'h06);
    // R5: trigger reload
    wr(3'd0, 8'h0E);
    trig_pin = 1'b0; steps(3); trig_pin = 1'b1; steps(2);
    rd16(3'd1, v); chk("R5 trigger reload", v, 16'hFFF0);
    rd(3'd0, v);   chk("R7 external flag", v, 8'h4E);
    // R6: trigger capture
    wr(3'd0, 8'h0F); wr(3'd1, 8'h34); wr(3'd2, 8'h12);
    trig_pin = 1'b0; steps(3); trig_pin = 1'b1; steps(2);
    rd16(3'd3, v); chk("R6 capture", v, 16'h1234);
    // R9: baud mode
    tick_en = 1'b0;
    wr(3'd3, 8'hFC); wr(3'd4, 8'hFF); wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    tick_en = 1'b1; wr(3'd0, 8'h35);
    nt = 0;
    for (int k = 0; k < 10; k++) begin step(); nt += baud_tx_tick; end
    chk("R9 tick count", nt, 3);
    rd(3'd0, v); chk("R8 no flag in baud mode", v, 8'h35);
    rd16(3'd1, v); chk("R9 baud reload", v, 16'hFFFC);
    // mixed pseudo-random stretch, model compared every cycle
    lfsr = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick_en = lfsr[0]; cnt_pin = lfsr[3]; trig_pin = lfsr[5] | lfsr[6];
      irq_en = lfsr[7];
      if (lfsr[11:8] == 4'd0) begin
        wr_en = 1'b1; addr = 3'(lfsr[14:12] % 5); wdata = lfsr[7:0] ^ lfsr[15:8];
      end else if (lfsr[11:8] == 4'd1) begin
        bit_wr = 1'b1; bit_idx = lfsr[14:12]; bit_val = lfsr[15];
      end
      step();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule